// File: doc/BRIEF.md
# SD Card Bring-up and Multi-Block Read Sequencer

This block is the control layer that sits above a command-line engine in an SD card host. After reset it takes the card through its bring-up sequence. That sequence has these parts: the reset command, the interface-condition probe, the repeated operating-condition negotiation, identification, relative-address assignment, card select, the 4-bit bus-width setup, the high-speed function switch and the block-length setup. The block then waits for read jobs. Each job is a multi-block read that opens with CMD18 and closes with CMD12.

The command engine is driven through a one-cycle request that carries a command index, a 32-bit argument and an expected response type. The engine answers with a response-valid or a timeout strobe and a 32-bit response payload. A separate data receiver is enabled while sector data flows. It reports one strobe per received 512-byte block, and it reports when it has gone idle. The sequencer also selects the SD clock rate. It exposes its 4-bit state code and the detected card type.

Top module: `sdseq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the state code is 0, the card type is 0 and the clock-rate code is 0. In that first cycle a request for CMD0 with response type 0 (none) is presented, and the state leaves 0 when the engine acknowledges it.
- R2: A successful bring-up issues commands in this order: 0, 8, then 55/41 pairs, then 2, 3, 7, 55, 6, 6, 16. The state codes run 0 CMD0, 1 CMD8, 2 CMD55, 3 ACMD41, 4 CMD2, 5 CMD3, 6 CMD7, 7 CMD55, 8 ACMD6, 9 CMD6, 10 CMD16, 11 ready/prepare read, 12 CMD18 response wait, 13 data receive, 14 CMD12, 15 wait for receiver idle. Bring-up ends in state 11.
- R3: CMD8 carries argument 0x000001AA. If payload bits 15:0 equal 0x01AA, the type becomes 2. If CMD8 times out, the type becomes 4 and the sequence goes on. Any other echo returns the state to 0.
- R4: ACMD41 carries 0x00FF8000, with bit 30 also set only when the type is 2. The CMD55/ACMD41 pair repeats until payload bit 31 of the ACMD41 response is 1.
- R5: The final type codes are 1 (SD1.0), 2 (SD2.0) and 3 (SDHC/XC). Type 4 becomes 1 when ACMD41 completes. Type 2 becomes 3 when payload bit 30 is set. Types 0 and 4 never appear in state 4 or above.
- R6: Payload bits 31:16 of the CMD3 response are stored. They form bits 31:16 of the CMD7 argument and of the second CMD55 argument, and the low 16 bits of both are 0.
- R7: ACMD6 carries 2, CMD6 carries 0x80FFFFF1 and CMD16 carries 512.
- R8: The clock-rate code is 0 (400 kHz) in states 0-6, 1 (25 MHz) in states 7-9 and 2 (50 MHz) in states 10-15.
- R9: A timeout on any outstanding command other than CMD8 puts the state to 0. Bring-up then starts over.
- R10: In state 11, a start pulse with a nonzero sector count issues CMD18. Its argument is the raw start sector for type 3 and start sector × 512 (low 32 bits) otherwise. A start pulse with a zero count, or a start outside state 11, has no effect.
- R11: The data enable is high in states 12 and 13. State 13 ends on the count-th block strobe, and CMD12 is then issued with argument 0. State 15 holds until the receiver reports idle, then returns to 11.
- R12: Each request is a one-cycle pulse in the first cycle of a command state. The response type is 2 (long) for CMD2, 3 (short with busy) for CMD7 and CMD12, and 1 for the rest apart from CMD0. The state does not move while a command is awaiting its answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read job start pulse |
| start_sector_i | input | 32 | First sector of the job |
| sector_cnt_i | input | CNT_W | Number of 512-byte sectors |
| cmd_req_o | output | 1 | Command request pulse |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_ty_o | output | 2 | Expected response: 0 none, 1 short, 2 long, 3 short+busy |
| rsp_valid_i | input | 1 | Response received |
| rsp_timeout_i | input | 1 | No response within the engine's limit |
| rsp_data_i | input | 32 | Response payload |
| dat_en_o | output | 1 | Data receiver enable |
| dat_blk_i | input | 1 | One block received |
| dat_idle_i | input | 1 | Data receiver idle |
| clk_rate_o | output | 2 | SD clock rate select |
| state_o | output | 4 | Sequencer state code |
| card_type_o | output | 3 | Detected card type |

## Verification
Some rules are checked by assertions on every cycle. These are: the one-cycle request pulse, that the state holds while a command is outstanding, the return to state 0 on a timeout, that a start is ignored unless it is accepted in state 11, that the block counter never decrements past zero, and that a provisional or unknown card type never reaches the identification states. Other behaviour shows only in the bench's scenarios, which sweep card kinds against busy-retry counts. These are: the exact command order, the argument values, the type decision, the per-state clock rate and the CMD18 address scaling. Recovery after a timeout and after a bad echo also shows only there.

// File: rtl/sdseq_pkg.sv
`timescale 1ns/1ps
package sdseq_pkg;
  typedef enum logic [3:0] {
    ST_RST   = 4'd0,  ST_IFC  = 4'd1,  ST_APP1  = 4'd2,  ST_OPC  = 4'd3,
    ST_CID   = 4'd4,  ST_RCA  = 4'd5,  ST_SEL   = 4'd6,  ST_APP2 = 4'd7,
    ST_BUSW  = 4'd8,  ST_HSW  = 4'd9,  ST_BLEN  = 4'd10, ST_RDY  = 4'd11,
    ST_RDRSP = 4'd12, ST_RDDAT = 4'd13, ST_STOP = 4'd14, ST_DRAIN = 4'd15
  } seq_st_e;

  typedef enum logic [2:0] {
    CT_UNK = 3'd0, CT_V1 = 3'd1, CT_V2 = 3'd2, CT_HC = 3'd3, CT_V1_MAYBE = 3'd4
  } card_ty_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0, RSP_SHORT = 2'd1, RSP_LONG = 2'd2, RSP_BUSY = 2'd3
  } rsp_ty_e;

  typedef enum logic [1:0] {
    CLK_ID = 2'd0, CLK_STD = 2'd1, CLK_HS = 2'd2
  } clk_rate_e;

  localparam logic [31:0] IF_COND_ARG   = 32'h0000_01AA;
  localparam logic [15:0] IF_COND_ECHO  = 16'h01AA;
  localparam logic [31:0] OCR_WIN       = 32'h00FF_8000;
  localparam logic [31:0] OCR_HCS       = 32'h4000_0000;
  localparam logic [31:0] HS_SWITCH_ARG = 32'h80FF_FFF1;
  localparam logic [31:0] BUS_4BIT_ARG  = 32'h0000_0002;
  localparam int          BLK_BYTES     = 512;
endpackage

// File: rtl/sdseq_cmd_gen.sv
`timescale 1ns/1ps
module sdseq_cmd_gen
  import sdseq_pkg::*;
(
  input  seq_st_e     st_i,
  input  card_ty_e    ty_i,
  input  logic [15:0] rca_i,
  input  logic [31:0] sect_i,
  output logic        is_cmd_o,
  output logic [5:0]  idx_o,
  output logic [31:0] arg_o,
  output rsp_ty_e     rty_o,
  output clk_rate_e   rate_o
);
  localparam int BLK_SH = $clog2(BLK_BYTES);

  always_comb begin
    is_cmd_o = 1'b1;
    idx_o    = 6'd0;
    arg_o    = 32'h0;
    rty_o    = RSP_SHORT;
    unique case (st_i)
      ST_RST:   rty_o = RSP_NONE;
      ST_IFC:   begin idx_o = 6'd8;  arg_o = IF_COND_ARG; end
      ST_APP1:  idx_o = 6'd55;
      ST_OPC:   begin
        idx_o = 6'd41;
        arg_o = OCR_WIN | ((ty_i == CT_V2) ? OCR_HCS : 32'h0);
      end
      ST_CID:   begin idx_o = 6'd2;  rty_o = RSP_LONG; end
      ST_RCA:   idx_o = 6'd3;
      ST_SEL:   begin idx_o = 6'd7;  arg_o = {rca_i, 16'h0}; rty_o = RSP_BUSY; end
      ST_APP2:  begin idx_o = 6'd55; arg_o = {rca_i, 16'h0}; end
      ST_BUSW:  begin idx_o = 6'd6;  arg_o = BUS_4BIT_ARG; end
      ST_HSW:   begin idx_o = 6'd6;  arg_o = HS_SWITCH_ARG; end
      ST_BLEN:  begin idx_o = 6'd16; arg_o = 32'(BLK_BYTES); end
      ST_RDRSP: begin
        idx_o = 6'd18;
        arg_o = (ty_i == CT_HC) ? sect_i : (sect_i << BLK_SH);
      end
      ST_STOP:  begin idx_o = 6'd12; rty_o = RSP_BUSY; end
      default:  is_cmd_o = 1'b0;
    endcase
  end

  // identification runs slow; select ends it; high-speed switch lifts it again
  always_comb begin
    if (st_i < ST_APP2)      rate_o = CLK_ID;
    else if (st_i < ST_BLEN) rate_o = CLK_STD;
    else                     rate_o = CLK_HS;
  end
endmodule

// File: rtl/sdseq_type_trk.sv
`timescale 1ns/1ps
module sdseq_type_trk
  import sdseq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seq_st_e  st_i,
  input  logic     wait_i,
  input  logic     rsp_valid_i,
  input  logic     rsp_timeout_i,
  input  logic     echo_ok_i,
  input  logic     ready_i,
  input  logic     ccs_i,
  output card_ty_e ty_o
);
  card_ty_e ty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ty_q <= CT_UNK;
    end else if (st_i == ST_RST) begin
      ty_q <= CT_UNK;
    end else if (wait_i) begin
      if (st_i == ST_IFC) begin
        if (rsp_timeout_i)                ty_q <= CT_V1_MAYBE;
        else if (rsp_valid_i && echo_ok_i) ty_q <= CT_V2;
      end else if (st_i == ST_OPC && rsp_valid_i && !rsp_timeout_i && ready_i) begin
        if (ty_q == CT_V1_MAYBE)      ty_q <= CT_V1;
        else if (ty_q == CT_V2 && ccs_i) ty_q <= CT_HC;
      end
    end
  end

  assign ty_o = ty_q;

  a_r5_final_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i > ST_OPC) |-> (ty_q != CT_V1_MAYBE && ty_q != CT_UNK));
  a_r5_hc_from_v2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ty_q == CT_HC && $past(ty_q) != CT_HC) |-> ($past(ty_q) == CT_V2));
endmodule

// File: rtl/sdseq_blk_cnt.sv
`timescale 1ns/1ps
module sdseq_blk_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rem_q <= '0;
    else if (load_i)                rem_q <= cnt_i;
    else if (tick_i && rem_q != '0) rem_q <= rem_q - ONE;
  end

  assign last_o = tick_i && (rem_q == ONE);

  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (rem_q != '0));
endmodule

// File: rtl/sdseq_top.sv
`timescale 1ns/1ps
module sdseq_top
  import sdseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      start_sector_i,
  input  logic [CNT_W-1:0] sector_cnt_i,
  output logic             cmd_req_o,
  output logic [5:0]       cmd_idx_o,
  output logic [31:0]      cmd_arg_o,
  output logic [1:0]       cmd_rsp_ty_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_timeout_i,
  input  logic [31:0]      rsp_data_i,
  output logic             dat_en_o,
  input  logic             dat_blk_i,
  input  logic             dat_idle_i,
  output logic [1:0]       clk_rate_o,
  output logic [3:0]       state_o,
  output logic [2:0]       card_type_o
);
  seq_st_e     st_q, st_d;
  logic        issued_q;
  logic [15:0] rca_q;
  logic [31:0] sect_q;
  card_ty_e    ty;
  rsp_ty_e     rty;
  clk_rate_e   rate;
  logic        is_cmd, rsp_ok, rsp_to, echo_ok, load, last, tick;

  assign rsp_ok  = issued_q && rsp_valid_i && !rsp_timeout_i;
  assign rsp_to  = issued_q && rsp_timeout_i;
  assign echo_ok = (rsp_data_i[15:0] == IF_COND_ECHO);
  assign load    = (st_q == ST_RDY) && start_i && (sector_cnt_i != '0);
  assign tick    = (st_q == ST_RDDAT) && dat_blk_i;

  sdseq_cmd_gen i_cmd_gen (
    .st_i    (st_q),
    .ty_i    (ty),
    .rca_i   (rca_q),
    .sect_i  (sect_q),
    .is_cmd_o(is_cmd),
    .idx_o   (cmd_idx_o),
    .arg_o   (cmd_arg_o),
    .rty_o   (rty),
    .rate_o  (rate)
  );

  sdseq_type_trk i_type_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_i         (st_q),
    .wait_i       (issued_q),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_timeout_i(rsp_timeout_i),
    .echo_ok_i    (echo_ok),
    .ready_i      (rsp_data_i[31]),
    .ccs_i        (rsp_data_i[30]),
    .ty_o         (ty)
  );

  sdseq_blk_cnt #(.CNT_W(CNT_W)) i_blk_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cnt_i (sector_cnt_i),
    .tick_i(tick),
    .last_o(last)
  );

  always_comb begin
    st_d = st_q;
    if (is_cmd && rsp_to) begin
      st_d = (st_q == ST_IFC) ? ST_APP1 : ST_RST;
    end else if (is_cmd && rsp_ok) begin
      unique case (st_q)
        ST_IFC:  st_d = echo_ok ? ST_APP1 : ST_RST;
        ST_OPC:  st_d = rsp_data_i[31] ? ST_CID : ST_APP1;
        default: st_d = seq_st_e'(st_q + 4'd1);
      endcase
    end else begin
      unique case (st_q)
        ST_RDY:   if (load)       st_d = ST_RDRSP;
        ST_RDDAT: if (last)       st_d = ST_STOP;
        ST_DRAIN: if (dat_idle_i) st_d = ST_RDY;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RST;
      issued_q <= 1'b0;
      rca_q    <= '0;
      sect_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q || rsp_ok || rsp_to) issued_q <= 1'b0;
      else if (cmd_req_o)                   issued_q <= 1'b1;
      if (st_q == ST_RCA && rsp_ok) rca_q  <= rsp_data_i[31:16];
      if (load)                     sect_q <= start_sector_i;
    end
  end

  assign cmd_req_o    = is_cmd && !issued_q;
  assign cmd_rsp_ty_o = rty;
  assign clk_rate_o   = rate;
  assign state_o      = st_q;
  assign card_type_o  = ty;
  assign dat_en_o     = (st_q == ST_RDRSP) || (st_q == ST_RDDAT);

  a_r12_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !cmd_req_o);
  a_r12_hold_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && !(issued_q && (rsp_valid_i || rsp_timeout_i))) |=> $stable(st_q));
  a_r9_timeout_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q && rsp_timeout_i && st_q != ST_IFC) |=> (st_q == ST_RST));
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RDY && !(start_i && sector_cnt_i != '0)) |=> (st_q == ST_RDY));
  a_r8_hs_needs_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_rate_o == 2'd2) |-> (card_type_o inside {3'd1, 3'd2, 3'd3}));
endmodule

// File: tb/test_sdseq_top.sv
`timescale 1ns/1ps
module test_sdseq_top;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [31:0]      start_sector_i = '0;
  logic [CNT_W-1:0] sector_cnt_i = '0;
  logic             cmd_req_o;
  logic [5:0]       cmd_idx_o;
  logic [31:0]      cmd_arg_o;
  logic [1:0]       cmd_rsp_ty_o;
  logic             rsp_valid_i = 1'b0;
  logic             rsp_timeout_i = 1'b0;
  logic [31:0]      rsp_data_i = '0;
  logic             dat_en_o;
  logic             dat_blk_i = 1'b0;
  logic             dat_idle_i = 1'b1;
  logic [1:0]       clk_rate_o;
  logic [3:0]       state_o;
  logic [2:0]       card_type_o;

  sdseq_top #(.CNT_W(CNT_W)) i_sdseq_top (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  // card model
  int kind = 1;          // 0 v1 (no CMD8 reply), 1 v2, 2 v2 high capacity, 3 bad echo
  int busy_rounds = 0;
  int acmd_cnt = 0;
  int drop_idx = -1;
  logic [15:0] rca_m = 16'h5A3C;
  logic [5:0]  log_idx [0:255];
  logic [31:0] log_arg [0:255];
  logic [1:0]  log_rt  [0:255];
  int n_log = 0;
  int rate_bad = 0, type_bad = 0, pulse_bad = 0;
  logic prev_req = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // responder: answers every request two cycles later
  initial begin
    forever begin
      @(negedge clk_i);
      while (rst_ni && cmd_req_o) begin
        int cur;
        cur = int'(cmd_idx_o);
        if (n_log < 256) begin
          log_idx[n_log] = cmd_idx_o;
          log_arg[n_log] = cmd_arg_o;
          log_rt[n_log]  = cmd_rsp_ty_o;
        end
        n_log++;
        repeat (2) @(negedge clk_i);
        if (cur == drop_idx || (cur == 8 && kind == 0)) begin
          rsp_timeout_i = 1'b1;
          if (cur == drop_idx) drop_idx = -1;
        end else begin
          rsp_valid_i = 1'b1;
          case (cur)
            8:  rsp_data_i = (kind == 3) ? 32'h0000_0155 : 32'h0000_01AA;
            41: begin
              if (acmd_cnt < busy_rounds) rsp_data_i = 32'h00FF_8000;
              else rsp_data_i = 32'h80FF_8000 | ((kind == 2) ? 32'h4000_0000 : 32'h0);
              acmd_cnt++;
            end
            3:  rsp_data_i = {rca_m, 16'h0500};
            55: rsp_data_i = 32'h0000_0120;
            default: rsp_data_i = 32'h0;
          endcase
        end
        @(negedge clk_i);
        rsp_valid_i = 1'b0;
        rsp_timeout_i = 1'b0;
      end
    end
  end

  // per-cycle monitor (R8 rate per state, R5 type, R12 pulse width)
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        int er;
        er = (state_o <= 4'd6) ? 0 : (state_o <= 4'd9) ? 1 : 2;
        if (int'(clk_rate_o) != er) rate_bad++;
        if (state_o >= 4'd4 && (card_type_o == 3'd4 || card_type_o == 3'd0)) type_bad++;
        if (cmd_req_o && prev_req) pulse_bad++;
        prev_req = cmd_req_o;
      end else prev_req = 1'b0;
    end
  end

  initial begin
    #(150000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic wait_state(input logic [3:0] s, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (state_o == s) return;
      @(negedge clk_i);
    end
  endtask

  function automatic int exp_idx(input int p, input int r);
    int pre;
    pre = 2 + 2 * (r + 1);
    if (p == 0) return 0;
    if (p == 1) return 8;
    if (p < pre) return ((p - 2) % 2 == 0) ? 55 : 41;
    case (p - pre)
      0: return 2;
      1: return 3;
      2: return 7;
      3: return 55;
      4: return 6;
      5: return 6;
      default: return 16;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    n_log = 0;
    acmd_cnt = 0;
    repeat (2) @(negedge clk_i);
    chk("R1 state in reset", 32'(state_o), 32'd0);
    chk("R1 type in reset", 32'(card_type_o), 32'd0);
    chk("R1 rate in reset", 32'(clk_rate_o), 32'd0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_init(input int k, input int r);
    int tot, seq_ok, acmd_ok;
    kind = k;
    busy_rounds = r;
    do_reset();
    wait_state(4'd11, 3000);
    tot = 9 + 2 * (r + 1);
    chk($sformatf("R2 ready state k%0d r%0d", k, r), 32'(state_o), 32'd11);
    chk("R2 command count", 32'(n_log), 32'(tot));
    seq_ok = 1;
    acmd_ok = 1;
    for (int p = 0; p < tot && p < 256; p++) begin
      if (int'(log_idx[p]) != exp_idx(p, r)) seq_ok = 0;
      if (log_idx[p] == 6'd41 &&
          log_arg[p] != (32'h00FF_8000 | ((k != 0) ? 32'h4000_0000 : 32'h0))) acmd_ok = 0;
    end
    chk("R2 command order", 32'(seq_ok), 32'd1);
    chk("R4 ACMD41 args and repeats", 32'(acmd_ok), 32'd1);
    chk("R1 CMD0 first, no response", {24'h0, log_idx[0], log_rt[0]}, 32'h0);
    chk("R3 CMD8 arg", log_arg[1], 32'h0000_01AA);
    chk("R12 CMD2 long", 32'(log_rt[tot - 7]), 32'd2);
    chk("R6 CMD7 rca", log_arg[tot - 5], {rca_m, 16'h0});
    chk("R12 CMD7 busy", 32'(log_rt[tot - 5]), 32'd3);
    chk("R6 CMD55 rca", log_arg[tot - 4], {rca_m, 16'h0});
    chk("R7 ACMD6 arg", log_arg[tot - 3], 32'd2);
    chk("R7 CMD6 arg", log_arg[tot - 2], 32'h80FF_FFF1);
    chk("R7 CMD16 arg", log_arg[tot - 1], 32'd512);
    chk("R5 final type", 32'(card_type_o), (k == 0) ? 32'd1 : (k == 1) ? 32'd2 : 32'd3);
    chk("R8 rate when ready", 32'(clk_rate_o), 32'd2);
  endtask

  task automatic run_read(input logic [31:0] sec, input int cnt);
    logic [31:0] ea;
    ea = (kind == 2) ? sec : (sec << 9);
    n_log = 0;
    dat_idle_i = 1'b0;
    @(negedge clk_i);
    start_sector_i = sec;
    sector_cnt_i = CNT_W'(cnt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    start_sector_i = 32'hDEAD_BEEF;
    wait_state(4'd13, 100);
    chk("R10 CMD18 issued", {26'h0, log_idx[0]}, 32'd18);
    chk("R10 CMD18 address", log_arg[0], ea);
    chk("R11 data enable", 32'(dat_en_o), 32'd1);
    for (int b = 0; b < cnt; b++) begin
      repeat (3) @(negedge clk_i);
      chk("R11 still receiving", 32'(state_o), 32'd13);
      dat_blk_i = 1'b1;
      @(negedge clk_i);
      dat_blk_i = 1'b0;
    end
    wait_state(4'd15, 100);
    chk("R11 CMD12 after last block", {26'h0, log_idx[1]}, 32'd12);
    chk("R11 CMD12 arg", log_arg[1], 32'd0);
    repeat (3) @(negedge clk_i);
    chk("R11 waits for idle", 32'(state_o), 32'd15);
    dat_idle_i = 1'b1;
    @(negedge clk_i);
    chk("R11 back to ready", 32'(state_o), 32'd11);
  endtask

  initial begin
    // sweep card kinds against busy-retry counts
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < 3; r++) begin
        run_init(k, r);
        run_read(32'h0000_1000 * k + 32'(r * 7) + ((r == 2) ? 32'hFFFF_F000 : 32'h0), r + 1);
      end
    end

    // zero-count start ignored
    n_log = 0;
    @(negedge clk_i);
    sector_cnt_i = '0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R10 zero count ignored state", 32'(state_o), 32'd11);
    chk("R10 zero count no command", 32'(n_log), 32'd0);

    // start outside ready ignored: pulse during bring-up
    kind = 1;
    busy_rounds = 0;
    do_reset();
    wait_state(4'd5, 200);
    sector_cnt_i = CNT_W'(4);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_state(4'd11, 3000);
    repeat (3) @(negedge clk_i);
    chk("R10 early start ignored", 32'(state_o), 32'd11);

    // timeout on CMD3 restarts bring-up
    drop_idx = 3;
    do_reset();
    wait_state(4'd11, 3000);
    chk("R9 CMD0 after CMD3 timeout", {26'h0, log_idx[6]}, 32'd0);
    chk("R9 full retry count", 32'(n_log), 32'd17);
    chk("R9 ready after retry", 32'(state_o), 32'd11);

    // bad CMD8 echo returns to CMD0
    kind = 3;
    do_reset();
    for (int i = 0; i < 200 && n_log < 3; i++) @(negedge clk_i);
    chk("R3 CMD0 after bad echo", {26'h0, log_idx[2]}, 32'd0);
    kind = 1;
    wait_state(4'd11, 3000);
    chk("R3 recovers as SD2.0", 32'(card_type_o), 32'd2);

    chk("R8 rate per state", 32'(rate_bad), 32'd0);
    chk("R5 no provisional type late", 32'(type_bad), 32'd0);
    chk("R12 request pulse width", 32'(pulse_bad), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule